// File: doc/BRIEF.md
# Hold-State Sequencer with Warm-Up Timing

This block decides when the core clock is stopped for a low-power hold state and when it comes back. Software starts a hold by writing a 4-bit command word. The word selects one of two release styles and one of three oscillator warm-up lengths. A wake pin ends the hold. In level style the pin being high ends it. In edge style only a low-to-high transition ends it. After release the oscillator runs for the selected warm-up while the CPU stays stalled. Execution then resumes with the interval time base cleared.

The block also contains the free-running time base. It is a 4-bit prescaler (divide by 16) that feeds an 18-bit counter, and it measures the warm-up. Clock stopping is shown as a gate-enable output, `osc_en`. `cpu_run` tells the core that it may execute. The wake pin goes through a two-stage synchronizer, and its inverted level is offered as a status bit.

Command word layout: bit 3 is the release style (1 = level, 0 = edge). Bits 2:1 are the warm-up select. Bit 0 starts the hold. Examples: 1101b means level release with 2^14 clocks, and 0101b means edge release with 2^14 clocks.

Top module: `hold_ctrl`

## Requirements
- R1: While `rst_n` is low, every rising edge puts the block in run state: `cpu_run`=1, `osc_en`=1, `tbase`=0, and the synchronizer is cleared, so `hold_stat_n`=1.
- R2: In run state, a write with bit 0 = 1 and bits 2:1 ≠ 00 takes effect at the next edge. The block enters hold (`osc_en`=0, `cpu_run`=0) and clears the prescaler and the counter. A write with bit 0 = 0 or bits 2:1 = 00 has no effect.
- R3: If bit 3 = 1 (level style) and the synchronized pin is already high at the write, hold is skipped. The warm-up starts at once, with `osc_en`=1 and `cpu_run`=0.
- R4: In level style, hold ends on the first edge at which the synchronized pin is high. Warm-up follows.
- R5: In edge style (bit 3 = 0), hold is entered whatever the pin level is. Only a synchronized low-to-high transition seen during hold ends it. A pin that stays high does not end it.
- R6: Warm-up select 01 lasts 2^16 clocks, 10 lasts 2^14 clocks and 11 lasts 2^12 clocks. Throughout the warm-up `osc_en`=1 and `cpu_run`=0. `cpu_run` returns to 1 on the edge that completes the count.
- R7: When the warm-up ends, the prescaler and the counter restart from 0. `tbase` reads 0 for the first 16 run cycles and reads 1 on the 17th.
- R8: Outside hold, `tbase` advances by one every 16 clocks. Reset clears the counter but not the prescaler, which keeps counting through reset.
- R9: A low `rst_n` during hold or warm-up returns the block to run state at the next edge.
- R10: `hold_stat_n` is the inverse of `hold_pin`, delayed by two clock edges.
- R11: Command writes made during hold or warm-up are ignored. The release style and the warm-up length already latched stay in force.
- R12: During hold, `tbase` stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Basic clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 4 | Command word: style, warm-up select, start |
| hold_pin | input | 1 | Wake pin, asynchronous |
| osc_en | output | 1 | Oscillator/clock gate enable, low during hold |
| cpu_run | output | 1 | Core may execute |
| hold_stat_n | output | 1 | Inverted synchronized wake-pin level |
| tbase | output | 18 | Time-base counter after the divide-by-16 prescaler |

## Verification
The assertions assume that reset is held for at least one edge before anything is judged. The status check also waits three edges after reset so that its two-cycle look-back only covers cycles after reset. They assume the wake pin, although it is asynchronous, changes only between edges. This holds because the stimulus drives every input on the falling edge. Command strobes last exactly one cycle. Writes made while the CPU is stalled are deliberately mixed into the stimulus, so the assertions about ignored writes are exercised and not just left vacuous.

// File: rtl/hm_pkg.sv
package hm_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HOLD = 2'd1,
        ST_WARM = 2'd2
    } hm_state_e;

    localparam int CMD_W       = 4;
    localparam int CMD_START   = 0;
    localparam int CMD_WSEL_LO = 1;
    localparam int CMD_STYLE   = 3;

    typedef struct packed {
        hm_state_e   state;
        logic        lvl_style;
        logic [1:0]  wsel;
    } hm_ctrl_s;

    function automatic logic [1:0] cmd_wsel(input logic [CMD_W-1:0] c);
        return c[CMD_WSEL_LO +: 2];
    endfunction

    function automatic logic cmd_is_hold(input logic [CMD_W-1:0] c);
        return c[CMD_START] && (cmd_wsel(c) != 2'b00);
    endfunction

endpackage

// File: rtl/hold_pin_sync.sv
module hold_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic lvl_o,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } ps_s;

    ps_s ps_d, ps_q;

    assign lvl_o  = ps_q.sync[STAGES-1];
    assign rise_o = ps_q.sync[STAGES-1] & ~ps_q.prev;

    always_comb begin
        ps_d.sync = {ps_q.sync[STAGES-2:0], pin_i};
        ps_d.prev = ps_q.sync[STAGES-1];
        if (!rst_n) begin
            ps_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        ps_q <= ps_d;
    end
endmodule

// File: rtl/hold_timebase.sv
module hold_timebase #(
    parameter int PRESC_W = 4,
    parameter int CNT_W   = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               freeze_i,
    output logic [PRESC_W-1:0] presc_o,
    output logic [CNT_W-1:0]   cnt_o
);
    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic [CNT_W-1:0]   cnt;
    } tb_s;

    tb_s tb_d, tb_q;
    logic presc_wrap;

    assign presc_wrap = &tb_q.presc;
    assign presc_o    = tb_q.presc;
    assign cnt_o      = tb_q.cnt;

    always_comb begin
        tb_d = tb_q;
        if (clr_i) begin
            tb_d = '0;
        end else if (!freeze_i) begin
            tb_d.presc = tb_q.presc + 1'b1;
            tb_d.cnt   = tb_q.cnt + CNT_W'(presc_wrap);
        end
        // reset reaches the counter only; the prescaler keeps running
        if (!rst_n) begin
            tb_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        tb_q <= tb_d;
    end
endmodule

// File: rtl/hold_wu_decode.sv
module hold_wu_decode #(
    parameter int CHAIN_W = 22,
    parameter int EXP_S1  = 16,
    parameter int EXP_S2  = 14,
    parameter int EXP_S3  = 12
) (
    input  logic [CHAIN_W-1:0] chain_i,
    input  logic [1:0]         wsel_i,
    output logic               last_o
);
    logic [2:0] hit;

    for (genvar g = 0; g < 3; g++) begin : g_sel
        localparam int EXP = (g == 0) ? EXP_S1 : (g == 1) ? EXP_S2 : EXP_S3;
        localparam logic [CHAIN_W-1:0] MASK = {CHAIN_W{1'b1}} >> (CHAIN_W - EXP);
        assign hit[g] = &(chain_i | ~MASK);
    end

    always_comb begin
        case (wsel_i)
            2'b01:   last_o = hit[0];
            2'b10:   last_o = hit[1];
            2'b11:   last_o = hit[2];
            default: last_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/hold_ctrl.sv
module hold_ctrl #(
    parameter int PRESC_W     = 4,
    parameter int CNT_W       = 18,
    parameter int SYNC_STAGES = 2,
    parameter int WU_EXP_S1   = 16,
    parameter int WU_EXP_S2   = 14,
    parameter int WU_EXP_S3   = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_we,
    input  logic [hm_pkg::CMD_W-1:0] cmd_data,
    input  logic                     hold_pin,
    output logic                     osc_en,
    output logic                     cpu_run,
    output logic                     hold_stat_n,
    output logic [CNT_W-1:0]         tbase
);
    import hm_pkg::*;

    localparam int CHAIN_W = PRESC_W + CNT_W;

    hm_ctrl_s           ctrl_d, ctrl_q;
    logic               pin_lvl, pin_rise;
    logic               tb_clr, tb_freeze;
    logic [PRESC_W-1:0] presc;
    logic [CNT_W-1:0]   cnt;
    logic               wu_last;
    logic               hold_req;

    hold_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (hold_pin),
        .lvl_o  (pin_lvl),
        .rise_o (pin_rise)
    );

    hold_timebase #(.PRESC_W(PRESC_W), .CNT_W(CNT_W)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (tb_clr),
        .freeze_i (tb_freeze),
        .presc_o  (presc),
        .cnt_o    (cnt)
    );

    hold_wu_decode #(
        .CHAIN_W (CHAIN_W),
        .EXP_S1  (WU_EXP_S1),
        .EXP_S2  (WU_EXP_S2),
        .EXP_S3  (WU_EXP_S3)
    ) u_dec (
        .chain_i ({cnt, presc}),
        .wsel_i  (ctrl_q.wsel),
        .last_o  (wu_last)
    );

    assign hold_req = cmd_we && cmd_is_hold(cmd_data);

    always_comb begin
        ctrl_d    = ctrl_q;
        tb_clr    = 1'b0;
        tb_freeze = 1'b0;
        case (ctrl_q.state)
            ST_RUN: begin
                if (hold_req) begin
                    ctrl_d.lvl_style = cmd_data[CMD_STYLE];
                    ctrl_d.wsel      = cmd_wsel(cmd_data);
                    tb_clr           = 1'b1;
                    ctrl_d.state     = (cmd_data[CMD_STYLE] && pin_lvl) ? ST_WARM : ST_HOLD;
                end
            end
            ST_HOLD: begin
                tb_freeze = 1'b1;
                if (ctrl_q.lvl_style ? pin_lvl : pin_rise) begin
                    ctrl_d.state = ST_WARM;
                end
            end
            ST_WARM: begin
                if (wu_last) begin
                    tb_clr       = 1'b1;
                    ctrl_d.state = ST_RUN;
                end
            end
            default: ctrl_d.state = ST_RUN;
        endcase
        if (!rst_n) begin
            ctrl_d    = '{state: ST_RUN, lvl_style: 1'b0, wsel: 2'b00};
            tb_clr    = 1'b0;
            tb_freeze = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        ctrl_q <= ctrl_d;
    end

    assign osc_en      = (ctrl_q.state != ST_HOLD);
    assign cpu_run     = (ctrl_q.state == ST_RUN);
    assign hold_stat_n = ~pin_lvl;
    assign tbase       = cnt;
endmodule

// File: rtl/hold_ctrl_chk.sv
module hold_ctrl_chk #(
    parameter int CNT_W = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_we,
    input logic [3:0]       cmd_data,
    input logic             hold_pin,
    input logic             osc_en,
    input logic             cpu_run,
    input logic             hold_stat_n,
    input logic [CNT_W-1:0] tbase
);
    logic [1:0] since_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              since_q <= 2'd0;
        else if (since_q != 2'd3) since_q <= since_q + 2'd1;
    end

    p_reset_run_r9: assert property (@(posedge clk)
        !rst_n |=> (cpu_run && osc_en));

    p_stall_in_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !cpu_run);

    p_hold_counter_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (tbase == '0));

    p_cmd_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_run && cmd_we && (!cmd_data[0] || cmd_data[2:1] == 2'b00)) |=> cpu_run);

    p_level_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_run && cmd_we && cmd_data[0] && cmd_data[3] && cmd_data[2:1] != 2'b00
         && !hold_stat_n) |=> (osc_en && !cpu_run));

    p_edge_enter_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_run && cmd_we && cmd_data[0] && !cmd_data[3] && cmd_data[2:1] != 2'b00)
        |=> !osc_en);

    p_warm_no_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en && !cpu_run && cmd_we) |=> osc_en);

    p_status_sync_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q == 2'd3) |-> (hold_stat_n == !$past(hold_pin, 2)));

    p_tbase_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q != 2'd0) |-> (tbase == $past(tbase) || tbase == CNT_W'($past(tbase) + 1'b1)
                               || tbase == '0));
endmodule

bind hold_ctrl hold_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_we      (cmd_we),
    .cmd_data    (cmd_data),
    .hold_pin    (hold_pin),
    .osc_en      (osc_en),
    .cpu_run     (cpu_run),
    .hold_stat_n (hold_stat_n),
    .tbase       (tbase)
);

// File: tb/sim_hold_ctrl.sv
module sim_hold_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [3:0]  cmd_data = 4'h0;
    logic        hold_pin = 1'b0;
    logic        osc_en, cpu_run, hold_stat_n;
    logic [17:0] tbase;

    always #5 clk = ~clk;

    hold_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
        .hold_pin(hold_pin), .osc_en(osc_en), .cpu_run(cpu_run),
        .hold_stat_n(hold_stat_n), .tbase(tbase)
    );

    int     checks = 0;
    int     fails = 0;
    longint cyc = 0;

    // behavioural reference: 0 run, 1 hold, 2 warm
    int m_st = 0, m_psc = 0, m_cnt = 0, m_sel = 0;
    bit m_known = 0, m_mode = 0, m_s1 = 0, m_s2 = 0, m_prev = 0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic int wu_len(input int sel);
        return (sel == 1) ? (1 << 16) : (sel == 2) ? (1 << 14) : (1 << 12);
    endfunction

    task automatic m_inc();
        m_psc++;
        if (m_psc == 16) begin
            m_psc = 0;
            m_cnt = (m_cnt + 1) % (1 << 18);
        end
    endtask

    always @(posedge clk) begin
        bit rise;
        cyc++;
        rise = m_s2 && !m_prev;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_mode = 0; m_sel = 0;
            m_psc = (m_psc + 1) % 16;
            m_s1 = 0; m_s2 = 0; m_prev = 0;
        end else begin
            case (m_st)
                0: begin
                    if (cmd_we && cmd_data[0] && cmd_data[2:1] != 2'b00) begin
                        m_mode = cmd_data[3];
                        m_sel  = int'(cmd_data[2:1]);
                        m_psc = 0; m_cnt = 0; m_known = 1;
                        m_st = (m_mode && m_s2) ? 2 : 1;
                    end else m_inc();
                end
                1: if (m_mode ? m_s2 : rise) m_st = 2;
                default: begin
                    if (m_cnt * 16 + m_psc == wu_len(m_sel) - 1) begin
                        m_st = 0; m_psc = 0; m_cnt = 0;
                    end else m_inc();
                end
            endcase
            m_prev = m_s2; m_s2 = m_s1; m_s1 = hold_pin;
        end
    end

    always @(negedge clk) begin
        if (cyc > 0) begin
            chk("R2", "osc_en model", osc_en, m_st != 1);
            chk("R6", "cpu_run model", cpu_run, m_st == 0);
            chk("R10", "hold_stat_n model", hold_stat_n, !m_s2);
            if (m_known) chk("R7", "tbase model", tbase, m_cnt);
        end
    end

    always @(posedge clk) begin
        if (cyc > 180000) begin
            checks++; fails++;
            $display("FAIL R6 watchdog expired: actual %0d cycles expected < 180000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] v);
        cmd_we = 1'b1; cmd_data = v;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic wait_osc();
        for (int k = 0; k < 100 && !osc_en; k++) @(negedge clk);
    endtask

    task automatic count_warm(output int n, input int inject_at, input logic [3:0] v);
        n = 0;
        while (osc_en && !cpu_run && n < 70000) begin
            n++;
            if (n == inject_at) begin cmd_we = 1'b1; cmd_data = v; end
            @(negedge clk);
            cmd_we = 1'b0;
        end
    endtask

    initial begin
        int n;
        tick(4);
        chk("R1", "cpu_run in reset", cpu_run, 1);
        chk("R1", "osc_en in reset", osc_en, 1);
        chk("R1", "tbase in reset", tbase, 0);
        chk("R1", "hold_stat_n in reset", hold_stat_n, 1);
        rst_n = 1'b1;
        tick(3);

        // ignored commands
        wr(4'hE);
        chk("R2", "start bit clear ignored", cpu_run, 1);
        wr(4'h9);
        chk("R2", "select 00 ignored", osc_en, 1);

        // level style, pin low: hold, write during hold, release
        wr(4'hF);
        chk("R2", "enter hold osc_en", osc_en, 0);
        chk("R2", "enter hold cpu_run", cpu_run, 0);
        tick(20);
        chk("R12", "tbase frozen in hold", tbase, 0);
        wr(4'hB);
        chk("R11", "still in hold after write", osc_en, 0);
        hold_pin = 1'b1;
        wait_osc();
        count_warm(n, 0, 4'h0);
        chk("R4", "level release reached run", cpu_run, 1);
        chk("R11", "warm-up 2^12 kept after hold write", n, 4096);
        chk("R7", "tbase restart", tbase, 0);
        tick(15);
        chk("R7", "tbase after 15 run cycles", tbase, 0);
        tick(1);
        chk("R7", "tbase after 16 run cycles", tbase, 1);

        // level style, pin high: skip to warm-up; write during warm-up
        wr(4'hD);
        chk("R3", "skip hold osc_en", osc_en, 1);
        chk("R3", "skip hold cpu_run", cpu_run, 0);
        count_warm(n, 100, 4'hF);
        chk("R6", "warm-up 2^14 with write ignored R11", n, 16384);

        // edge style with pin high
        wr(4'h7);
        chk("R5", "edge style enters hold with pin high", osc_en, 0);
        tick(30);
        chk("R5", "high level does not release", osc_en, 0);
        hold_pin = 1'b0;
        tick(5);
        chk("R5", "falling pin does not release", osc_en, 0);
        hold_pin = 1'b1;
        wait_osc();
        chk("R5", "rising pin releases", osc_en, 1);
        count_warm(n, 0, 4'h0);
        chk("R6", "warm-up 2^12 after edge release", n, 4096);

        // longest warm-up
        hold_pin = 1'b0;
        tick(3);
        wr(4'hB);
        chk("R2", "hold with select 01", osc_en, 0);
        hold_pin = 1'b1;
        wait_osc();
        count_warm(n, 0, 4'h0);
        chk("R6", "warm-up 2^16", n, 65536);

        // reset does not clear the prescaler
        tick(5);
        rst_n = 1'b0;
        tick(1);
        chk("R8", "tbase cleared by reset", tbase, 0);
        rst_n = 1'b1;
        tick(9);
        chk("R8", "tbase before prescaler wrap", tbase, 0);
        tick(1);
        chk("R8", "prescaler phase kept through reset", tbase, 1);

        // reset during hold
        hold_pin = 1'b0;
        tick(3);
        wr(4'hF);
        chk("R2", "hold before reset", osc_en, 0);
        tick(10);
        rst_n = 1'b0;
        tick(1);
        chk("R9", "reset leaves hold cpu_run", cpu_run, 1);
        chk("R9", "reset leaves hold osc_en", osc_en, 1);
        rst_n = 1'b1;
        tick(2);

        // reset during warm-up
        hold_pin = 1'b1;
        tick(3);
        wr(4'hD);
        chk("R3", "warm before reset", cpu_run, 0);
        tick(50);
        rst_n = 1'b0;
        tick(1);
        chk("R9", "reset leaves warm-up cpu_run", cpu_run, 1);
        chk("R9", "reset leaves warm-up tbase", tbase, 0);
        rst_n = 1'b1;

        // status latency
        tick(4);
        chk("R10", "status with pin high", hold_stat_n, 0);
        hold_pin = 1'b0;
        tick(1);
        chk("R10", "status one edge after fall", hold_stat_n, 0);
        tick(1);
        chk("R10", "status two edges after fall", hold_stat_n, 1);

        tick(5);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule